// File: doc/BRIEF.md
# Edge-Selectable Fast External Interrupt

This block converts a small set of asynchronous input pins into interrupt requests. Each pin has a 2-bit trigger code in a software-visible control word. The code turns the pin off or makes it react to rising transitions, to falling transitions or to both. The pins are first brought into the system clock domain. A qualifying transition then sets a request flag for that pin. The flag drives the pin's interrupt output until software clears it.

Software uses a single register port. The select input picks between the control word and the flag word. A write to the control word replaces all trigger codes at once. In the flag word, a write with a bit set to one clears that pin's flag, and bits written as zero leave their flags alone. Reads are combinational on the same select. A pin's sampled history is kept up to date whatever its trigger code is. For this reason, switching a pin on never triggers on an old level difference. The same holds for a level that the pin already had while reset was active.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset the control word reads 0000h, the flag word reads 0000h and every request output is low.
- R2: With select 0 the control word is read and written. Pin 0's trigger code is in bits 1:0 and pin 1's code is in bits 3:2. All higher bits read as zero, even after a write of FFFFh.
- R3: Trigger code 00 disables a pin: no transition on it ever raises its request.
- R4: Trigger code 01 raises the request on a low-to-high transition only. A high-to-low transition is ignored.
- R5: Trigger code 10 raises the request on a high-to-low transition only. A low-to-high transition is ignored.
- R6: Trigger code 11 raises the request on either transition.
- R7: A pin level that is driven before a clock edge raises the request output just after the third rising clock edge that follows. There is no request after the first or second edge.
- R8: A request stays high until a write with select 1 puts a one in that pin's bit position (bit 0 for pin 0, bit 1 for pin 1). A write that puts a one only in other positions leaves the request set.
- R9: When a qualifying transition and a clear of the same pin fall in the same cycle, the request ends up set.
- R10: Turning a pin's trigger on while its level is steady raises no request. This includes a level that was held high through reset.
- R11: With select 1 the read data holds pin i's request flag in bit i. All higher bits read as zero.
- R12: Each pin's transitions affect only that pin's request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously, and its release must be synchronous to clk |
| pin_in | input | NPIN (2) | Asynchronous external pins |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the flag word (write 1 to clear) |
| reg_wdata | input | REG_W (16) | Write data |
| reg_rdata | output | REG_W (16) | Read data of the selected word |
| irq_req | output | NPIN (2) | Per-pin interrupt request, one bit per pin |

## Verification
The assertions check four things on every cycle. A request only rises when the pin's trigger code in the previous cycle was non-zero. With rising-only or falling-only codes, the synchronised level at that point has the matching polarity. A set request stays set unless its clear bit is written. Unused read bits stay zero. Other behaviour only shows up in the bench's timed scenarios: the exact three-edge latency, a clear colliding with a fresh transition, the lack of a request when a pin is switched on at a steady level or with a level held since reset, and the silence of a disabled pin. The bench also compares both outputs against a reference model on every clock.

// File: rtl/pin_edge_irq_pkg.sv
`timescale 1ns/1ps
package pin_edge_irq_pkg;

  localparam int MODE_W = 2;

  // trigger code per pin; the encoding is visible to software
  typedef enum logic [MODE_W-1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

endpackage

// File: rtl/pin_edge_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a vector of independent asynchronous bits.
module pin_edge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pin_edge_detect.sv
`timescale 1ns/1ps
// One pin: remembers the last synchronised level and qualifies the
// transition against the pin's trigger code.
module pin_edge_detect
  import pin_edge_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hist_ok,
  input  logic       lvl,
  input  edge_mode_e mode,
  output logic       hit
);

  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  // history always follows the level, whatever the mode
  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise = hist_ok & lvl & ~prev_q;
  assign fall = hist_ok & ~lvl & prev_q;

  always_comb begin
    case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pin_edge_regs.sv
`timescale 1ns/1ps
// Control word (trigger codes) and sticky request flags with read mux.
module pin_edge_regs #(
  parameter int NPIN   = 2,
  parameter int REG_W  = 16,
  parameter int CTRL_W = 2 * NPIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NPIN-1:0]   hit,
  output logic [CTRL_W-1:0] mode_q,
  output logic [NPIN-1:0]   flag_q,
  output logic [REG_W-1:0]  rd_data
);

  logic              ctrl_wr;
  logic              flag_wr;
  logic [CTRL_W-1:0] mode_d;
  logic [NPIN-1:0]   clr;
  logic [NPIN-1:0]   flag_d;

  assign ctrl_wr = wr_en & ~sel;
  assign flag_wr = wr_en & sel;

  always_comb begin
    mode_d = wr_data[CTRL_W-1:0];
    clr    = flag_wr ? wr_data[NPIN-1:0] : '0;
    // a fresh hit overrides a clear in the same cycle
    flag_d = (flag_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (ctrl_wr) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel) begin
      rd_data[NPIN-1:0] = flag_q;
    end else begin
      rd_data[CTRL_W-1:0] = mode_q;
    end
  end

  generate
    if (REG_W > CTRL_W) begin : g_spare
      logic unused_hi_bits;
      assign unused_hi_bits = ^wr_data[REG_W-1:CTRL_W];
    end
  endgenerate

endmodule

// File: rtl/pin_edge_irq.sv
`timescale 1ns/1ps
module pin_edge_irq
  import pin_edge_irq_pkg::*;
#(
  parameter int NPIN        = 2,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_in,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [NPIN-1:0]  irq_req
);

  localparam int CTRL_W = NPIN * MODE_W;
  // edges after reset until the stored history holds real samples
  localparam int WARM_N = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(WARM_N + 1);

  logic [NPIN-1:0]   sync_lvl;
  logic [NPIN-1:0]   edge_hit;
  logic [CTRL_W-1:0] mode_q;
  logic [WARM_W-1:0] warm_q;
  logic [WARM_W-1:0] warm_d;
  logic              hist_ok;

  assign hist_ok = (warm_q == WARM_W'(WARM_N));
  assign warm_d  = warm_q + WARM_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (!hist_ok) begin
      warm_q <= warm_d;
    end
  end

  pin_edge_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_lvl)
  );

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
      pin_edge_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .hist_ok (hist_ok),
        .lvl     (sync_lvl[g]),
        .mode    (edge_mode_e'(mode_q[MODE_W*g +: MODE_W])),
        .hit     (edge_hit[g])
      );
    end
  endgenerate

  pin_edge_regs #(
    .NPIN   (NPIN),
    .REG_W  (REG_W),
    .CTRL_W (CTRL_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .sel     (reg_sel),
    .wr_data (reg_wdata),
    .hit     (edge_hit),
    .mode_q  (mode_q),
    .flag_q  (irq_req),
    .rd_data (reg_rdata)
  );

endmodule

// File: rtl/pin_edge_irq_chk.sv
`timescale 1ns/1ps
module pin_edge_irq_chk #(
  parameter int NPIN  = 2,
  parameter int REG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_sel,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NPIN-1:0]   irq_req,
  input logic [2*NPIN-1:0] mode_q,
  input logic [NPIN-1:0]   sync_lvl
);

  localparam int CTRL_W = 2 * NPIN;

  assert_ctrl_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata >> CTRL_W) == '0);

  assert_flag_hi_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata >> NPIN) == '0);

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
      assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req[g]) |-> $past(mode_q[2*g +: 2]) != 2'b00);

      assert_rise_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req[g]) && $past(mode_q[2*g +: 2]) == 2'b01) |-> $past(sync_lvl[g]));

      assert_fall_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req[g]) && $past(mode_q[2*g +: 2]) == 2'b10) |-> !$past(sync_lvl[g]));

      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req[g] && !(reg_we && reg_sel && reg_wdata[g])) |=> irq_req[g]);
    end
  endgenerate

endmodule

bind pin_edge_irq pin_edge_irq_chk #(
  .NPIN  (NPIN),
  .REG_W (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_req   (irq_req),
  .mode_q    (mode_q),
  .sync_lvl  (sync_lvl)
);

// File: tb/pin_edge_irq_tb.sv
`timescale 1ns/1ps
module pin_edge_irq_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  pin_in;
  logic        reg_we;
  logic        reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [1:0]  irq_req;

  int checks;
  int failures;

  // reference model state
  logic [3:0] m_mode;
  logic [1:0] m_flag;
  logic [1:0] m_hist[$];

  pin_edge_irq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: update model from the inputs held over the edge, then compare
  task automatic cycle();
    logic [1:0] a;
    logic [1:0] b;
    logic [1:0] hit;
    logic [1:0] clr;
    @(posedge clk);
    hit = 2'b00;
    if (m_hist.size() >= 3) begin
      a = m_hist[m_hist.size()-2];
      b = m_hist[m_hist.size()-3];
      for (int i = 0; i < 2; i++) begin
        case (m_mode[2*i +: 2])
          2'b01:   hit[i] = a[i] && !b[i];
          2'b10:   hit[i] = !a[i] && b[i];
          2'b11:   hit[i] = a[i] != b[i];
          default: hit[i] = 1'b0;
        endcase
      end
    end
    clr = (reg_we && reg_sel) ? reg_wdata[1:0] : 2'b00;
    m_flag = (m_flag & ~clr) | hit;
    if (reg_we && !reg_sel) m_mode = reg_wdata[3:0];
    m_hist.push_back(pin_in);
    if (m_hist.size() > 3) void'(m_hist.pop_front());
    @(negedge clk);
    chk("R7 per-cycle irq_req vs model", int'(irq_req), int'(m_flag));
    chk("R2 per-cycle reg_rdata vs model", int'(reg_rdata),
        reg_sel ? int'({14'b0, m_flag}) : int'({12'b0, m_mode}));
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_wdata = d;
    cycle();
    reg_we    = 1'b0;
    reg_wdata = 16'h0000;
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks    = 0;
    failures  = 0;
    m_mode    = 4'h0;
    m_flag    = 2'b00;
    rst_n     = 1'b0;
    pin_in    = 2'b10;   // pin 1 held high through reset
    reg_we    = 1'b0;
    reg_sel   = 1'b0;
    reg_wdata = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    chk("R1 irq_req after reset", int'(irq_req), 0);
    chk("R1 control word after reset", int'(reg_rdata), 0);
    reg_sel = 1'b1;
    #1;
    chk("R1 flag word after reset", int'(reg_rdata), 0);
    reg_sel = 1'b0;

    // enable both edges immediately; pin 1 high since reset must not trigger
    wr(1'b0, 16'h000F);
    repeat (6) cycle();
    chk("R10 level held through reset gives no request", int'(irq_req), 0);

    wr(1'b0, 16'hFFFF);
    chk("R2 upper control bits read zero", int'(reg_rdata), 16'h000F);
    wr(1'b0, 16'h0009);   // pin0 rising, pin1 falling
    chk("R2 control readback", int'(reg_rdata), 16'h0009);

    pin_in[0] = 1'b1;
    cycle();
    cycle();
    chk("R7 no request after second edge", int'(irq_req[0]), 0);
    cycle();
    chk("R4 rising edge raises pin0 on third edge", int'(irq_req[0]), 1);
    chk("R12 pin1 unaffected by pin0", int'(irq_req[1]), 0);

    repeat (5) cycle();
    chk("R8 request held", int'(irq_req[0]), 1);
    wr(1'b1, 16'h0002);
    chk("R8 clear of other bit leaves pin0", int'(irq_req[0]), 1);
    wr(1'b1, 16'h0001);
    chk("R8 clear drops pin0", int'(irq_req[0]), 0);

    pin_in[0] = 1'b0;
    repeat (5) cycle();
    chk("R4 falling edge ignored in rising mode", int'(irq_req[0]), 0);

    pin_in[1] = 1'b0;
    repeat (3) cycle();
    chk("R5 falling edge raises pin1", int'(irq_req[1]), 1);
    chk("R12 pin0 unaffected by pin1", int'(irq_req[0]), 0);
    wr(1'b1, 16'h0002);
    pin_in[1] = 1'b1;
    repeat (5) cycle();
    chk("R5 rising edge ignored in falling mode", int'(irq_req[1]), 0);

    wr(1'b0, 16'h000B);   // pin0 any edge, pin1 falling
    pin_in[0] = 1'b1;
    repeat (3) cycle();
    chk("R6 rising edge in any-edge mode", int'(irq_req[0]), 1);
    wr(1'b1, 16'h0001);
    chk("R6 cleared before falling test", int'(irq_req[0]), 0);
    pin_in[0] = 1'b0;
    repeat (3) cycle();
    chk("R6 falling edge in any-edge mode", int'(irq_req[0]), 1);

    // edge arrives on the same edge as a clear
    pin_in[0] = 1'b1;
    cycle();
    cycle();
    reg_we    = 1'b1;
    reg_sel   = 1'b1;
    reg_wdata = 16'h0001;
    cycle();
    reg_we    = 1'b0;
    reg_wdata = 16'h0000;
    chk("R9 edge wins over clear", int'(irq_req[0]), 1);
    reg_sel = 1'b0;
    cycle();
    chk("R9 request stays after collision", int'(irq_req[0]), 1);

    pin_in[1] = 1'b0;
    repeat (3) cycle();
    reg_sel = 1'b1;
    #1;
    chk("R11 flag word layout", int'(reg_rdata), 16'h0003);
    reg_sel = 1'b0;

    wr(1'b1, 16'h0003);
    wr(1'b0, 16'h0000);
    pin_in = ~pin_in;
    repeat (4) cycle();
    pin_in = ~pin_in;
    repeat (4) cycle();
    chk("R3 disabled pins never request", int'(irq_req), 0);

    wr(1'b0, 16'h000F);
    repeat (5) cycle();
    chk("R10 enabling with steady pins gives no request", int'(irq_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule